// File: doc/BRIEF.md
# Real-Mode Physical Address Generator

This block turns a segment:offset pair into a 20-bit memory address. It owns the four segment registers: extra (ES), code (CS), stack (SS) and data (DS). Each cycle it takes the current base, index, instruction-pointer and stack-pointer values, a displacement and an addressing-mode code. From these it forms a 16-bit effective offset. It then picks a segment: the default for the mode, or an override where the mode accepts one. The result is the segment value times sixteen plus the offset.

Both the address and the effective offset are registered, so each appears one clock after the inputs that produce it. A write to a segment register takes effect at the same edge. An address computed in the same cycle as a write therefore still uses the old segment value.

Top module: `rm_phys_addr`

## Requirements
- R1: `phys_addr` equals (segment × 16 + offset) modulo 2^20, and `eff_off` equals the effective offset, both one clock after the inputs. While `rst_n` is low, both outputs and all four segment registers read zero.
- R2: When `seg_we` is high, `seg_wdata` is written to the segment chosen by `seg_sel` (0 = ES, 1 = CS, 2 = SS, 3 = DS). An address computed in the same cycle as the write uses the old value.
- R3: Mode 0 addresses CS:IP and mode 1 addresses SS:SP. Both ignore any override.
- R4: Mode 2 (direct) uses the displacement alone as the offset, with DS as the default segment.
- R5: Mode 3 (register indirect) uses the register chosen by `reg_sel` (0 = BX, 1 = BP, 2 = SI, 3 = DI) as the offset.
- R6: Mode 4 adds a base (`base_sel` 0 = BX, 1 = BP) to an index (`idx_sel` 0 = SI, 1 = DI). Mode 6 adds the displacement to that sum as well.
- R7: Mode 5 (register relative) adds the displacement to the register chosen by `reg_sel`.
- R8: In modes 2 to 6, the default segment is SS when BP takes part in the offset, and DS otherwise.
- R9: For modes 2 to 7, when `ovr_valid` is high, the segment chosen by `ovr_seg` (same encoding as `seg_sel`) replaces the default segment.
- R10: Mode 7 (string source) addresses DS:SI, and the override applies. Mode 8 (string destination) always addresses ES:DI, whatever the override inputs say.
- R11: When `disp_byte` is high, only `disp[7:0]` is used, sign-extended to 16 bits.
- R12: The effective offset wraps modulo 2^16 before the segment is added. The final sum wraps modulo 2^20, so FFFF:0010 gives 00000h.
- R13: Mode codes 9 to 15 behave exactly like mode 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| seg_we | input | 1 | Segment register write enable |
| seg_sel | input | 2 | Segment register to write (0 ES, 1 CS, 2 SS, 3 DS) |
| seg_wdata | input | 16 | Value to write |
| mode | input | 4 | Addressing-mode code |
| reg_sel | input | 2 | Single register for modes 3 and 5 |
| base_sel | input | 1 | Base register select (0 BX, 1 BP) |
| idx_sel | input | 1 | Index register select (0 SI, 1 DI) |
| reg_bx | input | 16 | BX value |
| reg_bp | input | 16 | BP value |
| reg_si | input | 16 | SI value |
| reg_di | input | 16 | DI value |
| reg_ip | input | 16 | Instruction pointer |
| reg_sp | input | 16 | Stack pointer |
| disp | input | 16 | Displacement |
| disp_byte | input | 1 | Use sign-extended low byte of `disp` |
| ovr_valid | input | 1 | Segment override present |
| ovr_seg | input | 2 | Override segment (0 ES, 1 CS, 2 SS, 3 DS) |
| phys_addr | output | 20 | Registered physical address |
| eff_off | output | 16 | Registered effective offset |

## Verification
The assertions assume that reset is asserted before the first clock edge. They also assume that every input is stable across the sampling edge, because each property compares an output with the inputs and segment values of the previous cycle. The stimulus changes inputs only on the falling edge. It holds reset for several cycles before any check. It draws random mode codes across all sixteen values, random register contents, and random segment writes, so writes and reads of the same segment often collide.

// File: rtl/rm_phys_addr.sv
module rm_phys_addr #(
  parameter int OFF_W     = 16,
  parameter int SEG_SHIFT = 4,
  parameter int MODE_W    = 4,
  localparam int ADDR_W   = OFF_W + SEG_SHIFT
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              seg_we,
  input  logic [1:0]        seg_sel,
  input  logic [OFF_W-1:0]  seg_wdata,
  input  logic [MODE_W-1:0] mode,
  input  logic [1:0]        reg_sel,
  input  logic              base_sel,
  input  logic              idx_sel,
  input  logic [OFF_W-1:0]  reg_bx,
  input  logic [OFF_W-1:0]  reg_bp,
  input  logic [OFF_W-1:0]  reg_si,
  input  logic [OFF_W-1:0]  reg_di,
  input  logic [OFF_W-1:0]  reg_ip,
  input  logic [OFF_W-1:0]  reg_sp,
  input  logic [OFF_W-1:0]  disp,
  input  logic              disp_byte,
  input  logic              ovr_valid,
  input  logic [1:0]        ovr_seg,
  output logic [ADDR_W-1:0] phys_addr,
  output logic [OFF_W-1:0]  eff_off
);

  localparam logic [1:0] S_ES = 2'd0;
  localparam logic [1:0] S_CS = 2'd1;
  localparam logic [1:0] S_SS = 2'd2;
  localparam logic [1:0] S_DS = 2'd3;

  localparam logic [MODE_W-1:0] M_FETCH  = MODE_W'(0);
  localparam logic [MODE_W-1:0] M_STACK  = MODE_W'(1);
  localparam logic [MODE_W-1:0] M_DIRECT = MODE_W'(2);
  localparam logic [MODE_W-1:0] M_IND    = MODE_W'(3);
  localparam logic [MODE_W-1:0] M_BIX    = MODE_W'(4);
  localparam logic [MODE_W-1:0] M_REL    = MODE_W'(5);
  localparam logic [MODE_W-1:0] M_BIXREL = MODE_W'(6);
  localparam logic [MODE_W-1:0] M_STRSRC = MODE_W'(7);
  localparam logic [MODE_W-1:0] M_STRDST = MODE_W'(8);

  logic [OFF_W-1:0] seg_q [4];

  for (genvar g = 0; g < 4; g++) begin : g_seg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                             seg_q[g] <= '0;
      else if (seg_we && seg_sel == 2'(g))    seg_q[g] <= seg_wdata;
    end
  end

  logic [OFF_W-1:0] disp_ext, one_reg, base_v, idx_v, off_n;
  logic [1:0]       dflt_seg, seg_pick;
  logic             ovr_ok;
  logic [ADDR_W-1:0] addr_n;

  assign disp_ext = disp_byte ? {{(OFF_W-8){disp[7]}}, disp[7:0]} : disp;
  assign base_v   = base_sel ? reg_bp : reg_bx;
  assign idx_v    = idx_sel  ? reg_di : reg_si;

  always_comb begin
    case (reg_sel)
      2'd0:    one_reg = reg_bx;
      2'd1:    one_reg = reg_bp;
      2'd2:    one_reg = reg_si;
      default: one_reg = reg_di;
    endcase
  end

  always_comb begin
    off_n    = reg_ip;
    dflt_seg = S_CS;
    ovr_ok   = 1'b0;
    case (mode)
      M_STACK:  begin off_n = reg_sp; dflt_seg = S_SS; end
      M_DIRECT: begin off_n = disp_ext; dflt_seg = S_DS; ovr_ok = 1'b1; end
      M_IND:    begin
        off_n = one_reg; dflt_seg = (reg_sel == 2'd1) ? S_SS : S_DS; ovr_ok = 1'b1;
      end
      M_BIX:    begin
        off_n = base_v + idx_v; dflt_seg = base_sel ? S_SS : S_DS; ovr_ok = 1'b1;
      end
      M_REL:    begin
        off_n = one_reg + disp_ext; dflt_seg = (reg_sel == 2'd1) ? S_SS : S_DS; ovr_ok = 1'b1;
      end
      M_BIXREL: begin
        off_n = base_v + idx_v + disp_ext; dflt_seg = base_sel ? S_SS : S_DS; ovr_ok = 1'b1;
      end
      M_STRSRC: begin off_n = reg_si; dflt_seg = S_DS; ovr_ok = 1'b1; end
      M_STRDST: begin off_n = reg_di; dflt_seg = S_ES; end
      default:  ;
    endcase
  end

  assign seg_pick = (ovr_ok && ovr_valid) ? ovr_seg : dflt_seg;
  assign addr_n   = {seg_q[seg_pick], {SEG_SHIFT{1'b0}}} + {{SEG_SHIFT{1'b0}}, off_n};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phys_addr <= '0;
      eff_off   <= '0;
    end else begin
      phys_addr <= addr_n;
      eff_off   <= off_n;
    end
  end

  AST_SEG_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    seg_we |=> seg_q[$past(seg_sel)] == $past(seg_wdata)); // R2

  AST_FETCH_CS_IP: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == M_FETCH) |=> phys_addr ==
      ({$past(seg_q[S_CS]), {SEG_SHIFT{1'b0}}} + {{SEG_SHIFT{1'b0}}, $past(reg_ip)})); // R3

  AST_DIRECT_DISP: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == M_DIRECT && !disp_byte) |=> eff_off == $past(disp)); // R4

  AST_BP_STACK_SEG: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == M_IND && reg_sel == 2'd1 && !ovr_valid) |=> phys_addr ==
      ({$past(seg_q[S_SS]), {SEG_SHIFT{1'b0}}} + {{SEG_SHIFT{1'b0}}, $past(reg_bp)})); // R8

  AST_DST_NO_OVR: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == M_STRDST) |=> phys_addr ==
      ({$past(seg_q[S_ES]), {SEG_SHIFT{1'b0}}} + {{SEG_SHIFT{1'b0}}, $past(reg_di)})); // R10

  AST_OFF_STABLE_IP: assert property (@(posedge clk) disable iff (!rst_n)
    (mode > M_STRDST) |=> eff_off == $past(reg_ip)); // R13

endmodule

// File: tb/test_rm_phys_addr.sv
`timescale 1ns/1ps
module test_rm_phys_addr;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic seg_we = 1'b0;
  logic [1:0] seg_sel = '0;
  logic [15:0] seg_wdata = '0;
  logic [3:0] mode = '0;
  logic [1:0] reg_sel = '0;
  logic base_sel = 1'b0, idx_sel = 1'b0;
  logic [15:0] reg_bx = '0, reg_bp = '0, reg_si = '0, reg_di = '0;
  logic [15:0] reg_ip = '0, reg_sp = '0, disp = '0;
  logic disp_byte = 1'b0, ovr_valid = 1'b0;
  logic [1:0] ovr_seg = '0;
  logic [19:0] phys_addr;
  logic [15:0] eff_off;

  int checks = 0, errors = 0;
  bit cmp_en = 1'b0, done = 1'b0;

  always #4 clk = ~clk;

  rm_phys_addr i_rm_phys_addr (
    .clk(clk), .rst_n(rst_n), .seg_we(seg_we), .seg_sel(seg_sel), .seg_wdata(seg_wdata),
    .mode(mode), .reg_sel(reg_sel), .base_sel(base_sel), .idx_sel(idx_sel),
    .reg_bx(reg_bx), .reg_bp(reg_bp), .reg_si(reg_si), .reg_di(reg_di),
    .reg_ip(reg_ip), .reg_sp(reg_sp), .disp(disp), .disp_byte(disp_byte),
    .ovr_valid(ovr_valid), .ovr_seg(ovr_seg), .phys_addr(phys_addr), .eff_off(eff_off)
  );

  int m_seg [4];
  int m_addr = 0, m_off = 0;
  string m_tag = "R1";
  int dv, pick, offv, sidx;
  bit can_ovr;

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 4; i++) m_seg[i] = 0;
      m_addr = 0; m_off = 0; m_tag = "R1";
    end else begin
      dv = disp_byte ? (disp[7] ? (32'hFF00 | int'(disp[7:0])) : int'(disp[7:0])) : int'(disp);
      pick = (reg_sel == 0) ? int'(reg_bx) : (reg_sel == 1) ? int'(reg_bp) :
             (reg_sel == 2) ? int'(reg_si) : int'(reg_di);
      can_ovr = 1'b1;
      case (int'(mode))
        1: begin offv = reg_sp; sidx = 2; can_ovr = 0; m_tag = "R3"; end
        2: begin offv = dv; sidx = 3; m_tag = "R4"; end
        3: begin offv = pick; sidx = (reg_sel == 1) ? 2 : 3; m_tag = "R5"; end
        4: begin offv = (base_sel ? reg_bp : reg_bx) + (idx_sel ? reg_di : reg_si);
                 sidx = base_sel ? 2 : 3; m_tag = "R6"; end
        5: begin offv = pick + dv; sidx = (reg_sel == 1) ? 2 : 3; m_tag = "R7"; end
        6: begin offv = (base_sel ? reg_bp : reg_bx) + (idx_sel ? reg_di : reg_si) + dv;
                 sidx = base_sel ? 2 : 3; m_tag = "R6"; end
        7: begin offv = reg_si; sidx = 3; m_tag = "R10"; end
        8: begin offv = reg_di; sidx = 0; can_ovr = 0; m_tag = "R10"; end
        0: begin offv = reg_ip; sidx = 1; can_ovr = 0; m_tag = "R3"; end
        default: begin offv = reg_ip; sidx = 1; can_ovr = 0; m_tag = "R13"; end
      endcase
      if (can_ovr && ovr_valid) sidx = ovr_seg;
      m_off  = offv % 65536;
      m_addr = (m_seg[sidx] * 16 + m_off) % 1048576;
      if (seg_we) m_seg[seg_sel] = int'(seg_wdata);
    end
  end

  always @(negedge clk) begin
    if (cmp_en) begin
      checks++;
      if (int'(phys_addr) != m_addr || int'(eff_off) != m_off) begin
        errors++;
        $display("FAIL %s model: addr %h off %h expected addr %h off %h",
                 m_tag, phys_addr, eff_off, 20'(m_addr), 16'(m_off));
      end
    end
  end

  task automatic expect_now(input logic [19:0] ea, input logic [15:0] eo, input string tag);
    checks++;
    if (phys_addr !== ea || eff_off !== eo) begin
      errors++;
      $display("FAIL %s: addr %h off %h expected addr %h off %h", tag, phys_addr, eff_off, ea, eo);
    end
  endtask

  task automatic step;
    @(negedge clk);
  endtask

  task automatic wr_seg(input logic [1:0] s, input logic [15:0] v);
    seg_we = 1'b1; seg_sel = s; seg_wdata = v;
    step();
    seg_we = 1'b0;
  endtask

  task automatic finish_run;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not complete, actual timeout expected completion");
      finish_run();
    end
  end

  initial begin
    repeat (3) step();
    expect_now(20'h0, 16'h0, "R1 reset");
    rst_n = 1'b1;
    step();
    cmp_en = 1'b1;
    expect_now(20'h0, 16'h0, "R1 segments cleared");

    wr_seg(2'd1, 16'h1400);
    wr_seg(2'd2, 16'h2000);
    wr_seg(2'd3, 16'h1000);
    wr_seg(2'd0, 16'h3000);

    mode = 4'd0; reg_ip = 16'h1200; step();
    expect_now(20'h15200, 16'h1200, "R3 fetch");
    ovr_valid = 1'b1; ovr_seg = 2'd3; step();
    expect_now(20'h15200, 16'h1200, "R3 fetch override ignored");
    ovr_valid = 1'b0;

    mode = 4'd1; reg_sp = 16'h0100; step();
    expect_now(20'h20100, 16'h0100, "R3 stack");

    mode = 4'd3; reg_sel = 2'd1; reg_bp = 16'h3000; step();
    expect_now(20'h23000, 16'h3000, "R8 R5 bp indirect");

    mode = 4'd2; disp = 16'h0050; step();
    expect_now(20'h10050, 16'h0050, "R4 direct");
    ovr_valid = 1'b1; ovr_seg = 2'd0; step();
    expect_now(20'h30050, 16'h0050, "R9 override");

    mode = 4'd8; ovr_seg = 2'd1; reg_di = 16'h0100; step();
    expect_now(20'h30100, 16'h0100, "R10 dst keeps ES");
    mode = 4'd7; reg_si = 16'h0200; step();
    expect_now(20'h14200, 16'h0200, "R10 src override");
    ovr_valid = 1'b0;

    mode = 4'd5; reg_sel = 2'd0; reg_bx = 16'h0010; disp = 16'h12F0; disp_byte = 1'b1; step();
    expect_now(20'h10000, 16'h0000, "R11 R12 byte disp wrap");
    disp_byte = 1'b0;

    mode = 4'd5; reg_sel = 2'd2; reg_si = 16'h0100; disp = 16'h0020; step();
    expect_now(20'h10120, 16'h0120, "R7 relative");

    mode = 4'd4; base_sel = 1'b0; idx_sel = 1'b0; reg_bx = 16'hFFFF; reg_si = 16'h0002; step();
    expect_now(20'h10001, 16'h0001, "R6 R12 base index wrap");
    mode = 4'd6; base_sel = 1'b1; idx_sel = 1'b1; reg_bp = 16'h0010; reg_di = 16'h0020;
    disp = 16'h0003; step();
    expect_now(20'h20033, 16'h0033, "R6 R8 base index disp");

    mode = 4'd13; reg_ip = 16'h1200; step();
    expect_now(20'h15200, 16'h1200, "R13 unused code");

    mode = 4'd0; reg_ip = 16'h0000;
    seg_we = 1'b1; seg_sel = 2'd1; seg_wdata = 16'h0001; step();
    seg_we = 1'b0;
    expect_now(20'h14000, 16'h0000, "R2 old value same cycle");
    step();
    expect_now(20'h00010, 16'h0000, "R2 new value");

    wr_seg(2'd3, 16'hFFFF);
    mode = 4'd2; disp = 16'h0010; step();
    expect_now(20'h00000, 16'h0010, "R12 20-bit wrap");

    for (int n = 0; n < 4000; n++) begin
      seg_we    = ($urandom_range(0, 3) == 0);
      seg_sel   = 2'($urandom_range(0, 3));
      seg_wdata = 16'($urandom);
      mode      = ($urandom_range(0, 5) == 0) ? 4'($urandom_range(9, 15)) : 4'($urandom_range(0, 8));
      reg_sel   = 2'($urandom_range(0, 3));
      base_sel  = 1'($urandom_range(0, 1));
      idx_sel   = 1'($urandom_range(0, 1));
      reg_bx = 16'($urandom); reg_bp = 16'($urandom); reg_si = 16'($urandom);
      reg_di = 16'($urandom); reg_ip = 16'($urandom); reg_sp = 16'($urandom);
      disp = 16'($urandom);
      disp_byte = 1'($urandom_range(0, 1));
      ovr_valid = 1'($urandom_range(0, 1));
      ovr_seg   = 2'($urandom_range(0, 3));
      step();
    end

    done = 1'b1;
    finish_run();
  end
endmodule